// File: doc/BRIEF.md
# I2C Target Sequential Memory Reader

This block is an I2C bus target that gives a bus controller read access to a byte-addressed memory of 128 KB. It watches the clock and data lines through a two-stage synchronizer in a system clock at least twenty times faster than the bus clock. It recognises START and STOP, and it answers one fixed 7-bit address. A write transaction to that address carries three bytes that together load a 17-bit read pointer. A read transaction streams bytes out of memory from that pointer, one address after another, until the controller declines a byte.

The target drives the data line only as an open-drain pull-down enable; the pad logic outside turns it into a low level. Memory bytes come in through a synchronous read port. The request side is valid/ready: the block raises `mrd_req_valid` with an address and holds both, unchanged, until it sees `mrd_req_ready` high at a clock edge. The response side has no ready, because the block always takes the data. `mrd_rsp_valid` must pulse once for each accepted request. The data must arrive before the bus clock falling edge that ends the current acknowledge cycle. The request is issued about three system cycles after the preceding falling edge, so memory has roughly one bus clock period to answer.

Top module: `i2c_seqrd_target`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits equal 0x21 (0x42 on the wire to write, 0x43 to read; the least significant bit is the direction, 0 meaning write). It acknowledges by pulling SDA low during the 9th SCL cycle.
- R2: An address byte with any other 7-bit address gets no acknowledge. The target then stays off the bus until the next START, and the read pointer is unchanged.
- R3: The pull-down enable changes only while SCL is low, and it is asserted only during an acknowledge cycle the target gives or a data bit it sends.
- R4: In a write transaction the three data bytes b0, b1, b2 are each acknowledged and set the pointer to {b0[0], b1, b2}.
- R5: A first write byte with any of bits 7..1 set gets no acknowledge and leaves the pointer unchanged. A fourth write byte also gets no acknowledge.
- R6: A read returns the byte at the pointer first, MSB first. It then returns bytes from consecutive addresses for as long as the controller acknowledges. After a NACK the target releases SDA.
- R7: After reset the pointer is 0, so a read with no prior write starts at address 0.
- R8: The pointer wraps from 0x1FFFF to 0 during a read burst.
- R9: The pointer advances by one for each byte sent, and it holds across transactions, so a later read continues after the last byte sent.
- R10: A repeated START at any point abandons the byte in progress and restarts address matching. A write cut short this way leaves the pointer unchanged.
- R11: A memory request keeps its valid and address stable until accepted, and stalls of the memory request side do not change the data returned.
- R12: A STOP returns the target to idle with SDA released. After reset SDA is released and no memory request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_pull_o | output | 1 | 1 = pull SDA low (open-drain enable) |
| mrd_req_valid | output | 1 | Memory read request valid |
| mrd_req_ready | input | 1 | Memory accepts the request at this edge |
| mrd_req_addr | output | 17 | Memory byte address |
| mrd_rsp_valid | input | 1 | Read data valid, one pulse per accepted request |
| mrd_rsp_data | input | 8 | Read data byte |

## Verification
The assertions take for granted that SDA never changes in the same synchronized cycle as an SCL edge. They also assume that memory responses come only for requests the memory has accepted. The stimulus keeps every SDA change at least eight system cycles away from an SCL edge, with a bus half-period of twenty cycles. The memory model answers exactly two cycles after each acceptance, after a stall of a programmable number of cycles on the request side. Repeated STARTs are issued only while the target has released SDA, as a legal controller would do.

// File: rtl/i2c_seqrd_pkg.sv
package i2c_seqrd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK
  } tgt_state_t;

  localparam int BYTE_BITS = 8;
  localparam int CNT_W     = $clog2(BYTE_BITS + 1);
endpackage

// File: rtl/i2c_seqrd_line_sync.sv
module i2c_seqrd_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic scl_m, scl_s, scl_d;
  logic sda_m, sda_s, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {scl_m, scl_s, scl_d} <= 3'b111;
      {sda_m, sda_s, sda_d} <= 3'b111;
    end else begin
      scl_m <= scl_i; scl_s <= scl_m; scl_d <= scl_s;
      sda_m <= sda_i; sda_s <= sda_m; sda_d <= sda_s;
    end
  end

  assign scl_lvl   = scl_s;
  assign sda_lvl   = sda_s;
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign bus_start = scl_s & scl_d & sda_d & ~sda_s;
  assign bus_stop  = scl_s & scl_d & ~sda_d & sda_s;

  // Input rule taken for granted: data never moves on a clock edge cycle.
  assert_sda_apart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s != scl_d) |-> (sda_s == sda_d));
endmodule

// File: rtl/i2c_seqrd_fetch.sv
module i2c_seqrd_fetch #(
  parameter int PTR_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [PTR_W-1:0] go_addr,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [PTR_W-1:0] req_addr,
  input  logic             rsp_valid,
  input  logic [7:0]       rsp_data,
  output logic [7:0]       byte_q
);
  logic waiting;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_addr  <= '0;
      waiting   <= 1'b0;
      byte_q    <= '0;
    end else begin
      if (go) begin
        req_valid <= 1'b1;
        req_addr  <= go_addr;
      end else if (req_valid && req_ready) begin
        req_valid <= 1'b0;
      end
      if (req_valid && req_ready) waiting <= 1'b1;
      else if (rsp_valid)         waiting <= 1'b0;
      if (rsp_valid && waiting) byte_q <= rsp_data;
    end
  end

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !go) |=> (req_valid && $stable(req_addr)));

  // Input rule taken for granted: responses only follow accepted requests.
  assert_rsp_expected_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> waiting);
endmodule

// File: rtl/i2c_seqrd_target.sv
module i2c_seqrd_target
  import i2c_seqrd_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h21,
  parameter int         PTR_W       = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_pull_o,
  output logic             mrd_req_valid,
  input  logic             mrd_req_ready,
  output logic [PTR_W-1:0] mrd_req_addr,
  input  logic             mrd_rsp_valid,
  input  logic [7:0]       mrd_rsp_data
);
  localparam int HI_W = PTR_W - 16;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_BITS);

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;
  tgt_state_t state;
  logic [CNT_W-1:0] cnt;
  logic [7:0] rx_sh, tx_sh, fetch_byte;
  logic [1:0] wr_idx;
  logic [HI_W-1:0] hi_q;
  logic [7:0] mid_q;
  logic [PTR_W-1:0] ptr;
  logic rd_dir, ack_seen, pull_q, fetch_go;
  logic [7:0] rx_next;
  logic addr_hit;

  i2c_seqrd_line_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .bus_start(bus_start), .bus_stop(bus_stop)
  );

  assign rx_next  = {rx_sh[6:0], sda_lvl};
  assign addr_hit = (rx_sh[7:1] == TARGET_ADDR);
  // Prefetch: at the end of a read address byte, and at the end of each sent byte.
  assign fetch_go = scl_fall && (cnt == FULL) &&
                    ((state == ST_ADDR && addr_hit && rx_sh[0]) || state == ST_RD_BYTE);

  i2c_seqrd_fetch #(.PTR_W(PTR_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .go(fetch_go), .go_addr(ptr),
    .req_valid(mrd_req_valid), .req_ready(mrd_req_ready), .req_addr(mrd_req_addr),
    .rsp_valid(mrd_rsp_valid), .rsp_data(mrd_rsp_data), .byte_q(fetch_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      wr_idx   <= '0;
      hi_q     <= '0;
      mid_q    <= '0;
      ptr      <= '0;
      rd_dir   <= 1'b0;
      ack_seen <= 1'b0;
      pull_q   <= 1'b0;
    end else if (bus_start) begin
      state  <= ST_ADDR;
      cnt    <= '0;
      pull_q <= 1'b0;
    end else if (bus_stop) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      pull_q <= 1'b0;
    end else begin
      case (state)
        ST_ADDR: begin
          if (scl_rise && cnt != FULL) begin
            rx_sh <= rx_next;
            cnt   <= cnt + 1'b1;
          end else if (scl_fall && cnt == FULL) begin
            cnt <= '0;
            if (addr_hit) begin
              pull_q <= 1'b1;
              rd_dir <= rx_sh[0];
              wr_idx <= '0;
              state  <= ST_ADDR_ACK;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt <= '0;
            if (rd_dir) begin
              tx_sh  <= fetch_byte;
              pull_q <= ~fetch_byte[7];
              ptr    <= ptr + 1'b1;
              state  <= ST_RD_BYTE;
            end else begin
              pull_q <= 1'b0;
              state  <= ST_WR_BYTE;
            end
          end
        end
        ST_WR_BYTE: begin
          if (scl_rise && cnt != FULL) begin
            rx_sh <= rx_next;
            cnt   <= cnt + 1'b1;
          end else if (scl_fall && cnt == FULL) begin
            cnt <= '0;
            case (wr_idx)
              2'd0: begin
                if ((rx_sh >> HI_W) != 8'd0) begin
                  state <= ST_IDLE;
                end else begin
                  hi_q   <= rx_sh[HI_W-1:0];
                  pull_q <= 1'b1;
                  state  <= ST_WR_ACK;
                end
              end
              2'd1: begin
                mid_q  <= rx_sh;
                pull_q <= 1'b1;
                state  <= ST_WR_ACK;
              end
              2'd2: begin
                ptr    <= {hi_q, mid_q, rx_sh};
                pull_q <= 1'b1;
                state  <= ST_WR_ACK;
              end
              default: state <= ST_IDLE;
            endcase
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            pull_q <= 1'b0;
            cnt    <= '0;
            wr_idx <= wr_idx + 1'b1;
            state  <= ST_WR_BYTE;
          end
        end
        ST_RD_BYTE: begin
          if (scl_rise) begin
            cnt <= cnt + 1'b1;
          end else if (scl_fall) begin
            if (cnt == FULL) begin
              pull_q <= 1'b0;
              cnt    <= '0;
              state  <= ST_RD_ACK;
            end else begin
              tx_sh  <= {tx_sh[6:0], 1'b0};
              pull_q <= ~tx_sh[6];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            ack_seen <= ~sda_lvl;
          end else if (scl_fall) begin
            if (ack_seen) begin
              tx_sh  <= fetch_byte;
              pull_q <= ~fetch_byte[7];
              ptr    <= ptr + 1'b1;
              state  <= ST_RD_BYTE;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_pull_o = pull_q;

  assert_pull_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull_o |-> (state inside {ST_ADDR_ACK, ST_WR_ACK, ST_RD_BYTE}));

  assert_pull_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull_o != $past(sda_pull_o)) |-> !scl_lvl);

  assert_stop_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> !sda_pull_o);

  assert_ptr_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr != $past(ptr)) |-> ((ptr == $past(ptr) + 1'b1) || ($past(state) == ST_WR_BYTE)));
endmodule

// File: tb/test_i2c_seqrd_target.sv
`timescale 1ns/1ps
module test_i2c_seqrd_target;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_c = 1'b1, sda_c = 1'b1;
  logic sda_pull;
  logic req_valid, req_ready, rsp_valid;
  logic [16:0] req_addr;
  logic [7:0] rsp_data;
  wire sda_line = sda_c & ~sda_pull;

  int n_chk = 0, n_fail = 0;
  int stall_len = 0, stall_cnt = 0;
  logic acc_pend = 1'b0, hold_wait = 1'b0;
  logic [16:0] acc_addr = '0, hold_addr = '0;
  logic [16:0] model_ptr = '0;
  string cur_tag = "R6";
  logic [7:0] exp_q[$];
  logic [7:0] obs_q[$];

  always #10 clk = ~clk;

  i2c_seqrd_target i_i2c_seqrd_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_c), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .mrd_req_valid(req_valid), .mrd_req_ready(req_ready),
    .mrd_req_addr(req_addr), .mrd_rsp_valid(rsp_valid), .mrd_rsp_data(rsp_data)
  );

  function automatic logic [7:0] mem_byte(logic [16:0] a);
    return a[7:0] ^ {a[14:8], a[16]} ^ 8'hA5;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Memory model: stalls the request side, answers two cycles after acceptance.
  always @(posedge clk) begin
    if (!rst_n) begin
      req_ready <= 1'b0; rsp_valid <= 1'b0; rsp_data <= '0;
      acc_pend <= 1'b0; stall_cnt <= 0; hold_wait <= 1'b0;
    end else begin
      if (hold_wait) chk("R11 request held", {req_valid, req_addr}, {1'b1, hold_addr});
      hold_wait <= req_valid && !req_ready;
      hold_addr <= req_addr;
      rsp_valid <= acc_pend;
      rsp_data  <= mem_byte(acc_addr);
      acc_pend  <= req_valid && req_ready;
      if (req_valid && req_ready) begin
        acc_addr  <= req_addr;
        req_ready <= 1'b0;
        stall_cnt <= 0;
      end else if (req_valid) begin
        if (stall_cnt >= stall_len) req_ready <= 1'b1;
        else stall_cnt <= stall_cnt + 1;
      end
    end
  end

  // Scoreboard monitor.
  initial begin
    forever begin
      logic [7:0] got;
      wait (obs_q.size() != 0);
      got = obs_q.pop_front();
      if (exp_q.size() == 0) chk({cur_tag, " unexpected byte"}, got, -1);
      else chk({cur_tag, " read data"}, got, exp_q.pop_front());
    end
  end

  task automatic w(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(logic b);
    w(8); sda_c = b; w(12); scl_c = 1'b1; w(20); scl_c = 1'b0;
  endtask

  task automatic bit_in(output logic v);
    w(8); sda_c = 1'b1; w(12); scl_c = 1'b1; w(10); v = sda_line; w(10); scl_c = 1'b0;
  endtask

  task automatic bus_start();
    w(8); sda_c = 1'b1; w(12); scl_c = 1'b1; w(10); sda_c = 1'b0; w(10); scl_c = 1'b0;
  endtask

  task automatic bus_stop();
    w(8); sda_c = 1'b0; w(12); scl_c = 1'b1; w(10); sda_c = 1'b1; w(10);
  endtask

  task automatic send_byte(logic [7:0] b, output logic acked);
    logic v;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(v);
    acked = !v;
  endtask

  task automatic recv_byte(logic last);
    logic [7:0] b;
    logic v;
    for (int i = 7; i >= 0; i--) begin bit_in(v); b[i] = v; end
    bit_out(last);
    obs_q.push_back(b);
  endtask

  task automatic read_burst(int n, string tag);
    logic a;
    cur_tag = tag;
    bus_start();
    send_byte(8'h43, a);
    chk("R1 read address ack", a, 1);
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(mem_byte(model_ptr));
      model_ptr = model_ptr + 1'b1;
      recv_byte(k == n - 1);
    end
    w(4);
    chk("R6 SDA released after NACK", sda_pull, 0);
    bus_stop();
    w(4);
    chk("R12 SDA released after STOP", sda_pull, 0);
  endtask

  task automatic write_ptr(logic [7:0] b0, logic [7:0] b1, logic [7:0] b2);
    logic a;
    bus_start();
    send_byte(8'h42, a); chk("R1 write address ack", a, 1);
    send_byte(b0, a);    chk("R4 byte0 ack", a, 1);
    send_byte(b1, a);    chk("R4 byte1 ack", a, 1);
    send_byte(b2, a);    chk("R4 byte2 ack", a, 1);
    model_ptr = {b0[0], b1, b2};
  endtask

  initial begin
    logic a;
    w(5);
    rst_n = 1'b1;
    w(3);
    chk("R12 reset SDA released", sda_pull, 0);
    chk("R12 reset no request", req_valid, 0);

    // R7: first read starts at address 0; R6 consecutive bytes.
    read_burst(4, "R7");
    // R9: next read continues after the last byte sent.
    read_burst(2, "R9");

    // R2: other addresses ignored, pointer unchanged.
    bus_start(); send_byte(8'hA0, a); chk("R2 nack other address", a, 0); bus_stop();
    bus_start(); send_byte(8'h45, a); chk("R2 nack other read address", a, 0); bus_stop();
    read_burst(1, "R2");

    // R4 then R6: 16 bytes from 0x000080 with a slow memory (R11).
    stall_len = 12;
    write_ptr(8'h00, 8'h00, 8'h80); bus_stop();
    read_burst(16, "R6");
    stall_len = 0;

    // R5: bad first byte refused, pointer unchanged.
    bus_start(); send_byte(8'h42, a); chk("R1 write address ack", a, 1);
    send_byte(8'h02, a); chk("R5 bad first byte nack", a, 0); bus_stop();
    read_burst(1, "R5");
    // R5: fourth write byte refused, three-byte pointer kept.
    write_ptr(8'h00, 8'h00, 8'h10);
    send_byte(8'h33, a); chk("R5 fourth byte nack", a, 0); bus_stop();
    read_burst(2, "R5");

    // R8 with R10: wrap across 0x1FFFF, read after repeated START.
    write_ptr(8'h01, 8'hFF, 8'hFE);
    read_burst(4, "R8");

    // R10: repeated START mid-byte leaves the pointer alone.
    bus_start(); send_byte(8'h42, a); chk("R1 write address ack", a, 1);
    send_byte(8'h00, a); chk("R4 byte0 ack", a, 1);
    bit_out(1'b1); bit_out(1'b0); bit_out(1'b1); bit_out(1'b0);
    read_burst(2, "R10");

    w(50);
    chk("R6 all expected bytes seen", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule